// File: doc/BRIEF.md
# Vector Multiply-Accumulate Unit with Scalar and Per-Lane Accumulators

This block multiplies two 128-bit operand vectors lane by lane and accumulates the products. The lanes are 8 or 16 bits wide and can be signed or unsigned. One command is accepted per clock. A scalar multiply-accumulate adds the sum of every lane product into one 40-bit dot-product accumulator. A per-lane multiply-accumulate adds each lane's product into that lane's own accumulator. There are sixteen 20-bit per-lane accumulators for byte lanes, or eight 40-bit accumulators for halfword lanes. Both views share one 320-bit bank, so switching the lane width reinterprets the same bits.

Software-visible state is reached through 32-bit segment registers. The bank is split into a high half and a low half of five segments each. The scalar accumulator is split into a 32-bit low segment and an 8-bit high segment.

Two extraction commands bring results out:
- One shifts every per-lane accumulator right, saturates each to its lane width and packs the results into a 128-bit word.
- The other arithmetically shifts the scalar accumulator, writes the shifted value back and presents it saturated to signed 32 bits.

Separate commands clear each accumulator.

Top module: `vmac_acc`

## Requirements
- R1: After reset, both accumulators, `lane_out` and `scalar_out` are zero.
- R2: `op`=1 adds the sum of all lane products (16 byte lanes when `wide`=0, 8 halfword lanes when `wide`=1) to the 40-bit scalar accumulator. In signed mode the result clamps to [-2^39, 2^39-1]; in unsigned mode operands are zero-extended and the result clamps to [0, 2^40-1].
- R3: With `wide`=0, `op`=2 adds the product of byte lane i (`opa/opb[8i+7:8i]`) to the 20-bit accumulator at bank bits [20i+19:20i]. Signed results clamp to [-2^19, 2^19-1]; unsigned results clamp to [0, 2^20-1].
- R4: With `wide`=1, `op`=2 adds the product of halfword lane i (bits [16i+15:16i]) to the 40-bit accumulator at bank bits [40i+39:40i]. Results clamp to the signed or unsigned 40-bit range.
- R5: The bank is {high half, low half}. `reg_sel` 0..4 address high-half segments k (bank bits [160+32k+31:160+32k]), and `reg_sel` 5..9 address low-half segments k-5 (bits [32(k-5)+31:32(k-5)]). `reg_we`=1 writes `reg_wdata` at the clock edge, and `reg_rdata` shows the selected segment combinationally.
- R6: `reg_sel` 10 is scalar bits [31:0]. `reg_sel` 11 is scalar bits [39:32]: a write uses only `reg_wdata[7:0]`, and a read returns those 8 bits zero-padded. Other `reg_sel` values read zero.
- R7: `op`=5 registers into `lane_out` every per-lane accumulator shifted right by `shamt`, arithmetically when signed and logically when unsigned. Each result is clamped to 8 bits (byte lane i to `lane_out[8i+7:8i]`) or to 16 bits (halfword lane i to `[16i+15:16i]`), signed or unsigned.
- R8: `op`=6 arithmetically shifts the scalar accumulator right by `shamt` and writes the 40-bit result back. It also registers that result, clamped to [-2^31, 2^31-1], into `scalar_out`.
- R9: `op`=3 zeroes the scalar accumulator and `op`=4 zeroes the whole bank; each leaves the other accumulator unchanged.
- R10: A register write to an accumulator wins over any command that would change the same accumulator in that cycle. The command's update is dropped, and only the written segment changes.
- R11: `op`=0, `op`=7 and `op`=5 leave both accumulators unchanged, and every operation result appears one clock after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Command: 0 idle, 1 scalar MAC, 2 lane MAC, 3 clear scalar, 4 clear lanes, 5 lane extract, 6 scalar extract, 7 idle |
| wide | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| is_signed | input | 1 | 1: signed arithmetic, 0: unsigned |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| shamt | input | 6 | Right-shift amount for extraction |
| reg_we | input | 1 | Segment register write enable |
| reg_sel | input | 4 | Segment register select |
| reg_wdata | input | 32 | Segment write data |
| reg_rdata | output | 32 | Selected segment, combinational |
| lane_out | output | 128 | Packed per-lane extraction result |
| scalar_out | output | 32 | Saturated scalar extraction result |

## Verification
The hardest states to reach are accumulators sitting one step from a saturation limit. The 40-bit lanes need hundreds of maximal products to get there from zero. The bench therefore composes a full 320-bit bank image with lane values just below the signed and unsigned limits, writes it in through the ten segment registers, and then drives extreme operand pairs so the clamp engages within one or two steps. The same preload path sets up scalar values next to ±2^39 and the extraction corner shifts of 0, the lane width and 63. A write and a command aimed at the same accumulator are issued in one cycle to expose the priority rule.

// File: rtl/vmac_acc.sv
module vmac_acc #(
  parameter int VEC_W        = 128,
  parameter int NARROW_ACC_W = 20,
  parameter int WIDE_ACC_W   = 40,
  parameter int SCALAR_W     = 40,
  parameter int SEG_W        = 32,
  parameter int SEL_W        = 4,
  parameter int SH_W         = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op,
  input  logic             wide,
  input  logic             is_signed,
  input  logic [VEC_W-1:0] opa,
  input  logic [VEC_W-1:0] opb,
  input  logic [SH_W-1:0]  shamt,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [SEG_W-1:0] reg_wdata,
  output logic [SEG_W-1:0] reg_rdata,
  output logic [VEC_W-1:0] lane_out,
  output logic [SEG_W-1:0] scalar_out
);

  localparam int LN     = 8;
  localparam int LW     = 16;
  localparam int NL     = VEC_W / LN;
  localparam int WL     = VEC_W / LW;
  localparam int BANK_W = NL * NARROW_ACC_W;
  localparam int HALF_W = BANK_W / 2;
  localparam int NSEG   = HALF_W / SEG_W;
  localparam logic [SEL_W-1:0] SEL_SLO = SEL_W'(2 * NSEG);
  localparam logic [SEL_W-1:0] SEL_SHI = SEL_W'(2 * NSEG + 1);

  localparam logic [2:0] OP_MACS = 3'd1;
  localparam logic [2:0] OP_MACL = 3'd2;
  localparam logic [2:0] OP_CLRS = 3'd3;
  localparam logic [2:0] OP_CLRL = 3'd4;
  localparam logic [2:0] OP_XL   = 3'd5;
  localparam logic [2:0] OP_XS   = 3'd6;

  function automatic logic signed [63:0] sx64(input logic [63:0] v, input int w, input logic sg);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    if (sg && v[w-1]) return $signed(v | ~m);
    return $signed(v & m);
  endfunction

  function automatic logic signed [63:0] clip(input logic signed [63:0] v, input int w, input logic sg);
    logic signed [63:0] hi, lo;
    hi = sg ? (64'sd1 <<< (w - 1)) - 64'sd1 : (64'sd1 <<< w) - 64'sd1;
    lo = sg ? -(64'sd1 <<< (w - 1)) : 64'sd0;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int seg_pos(input int k);
    return (k < NSEG) ? HALF_W + SEG_W * k : SEG_W * (k - NSEG);
  endfunction

  logic [BANK_W-1:0]   bank_q, bank_d, bank_mac;
  logic [SCALAR_W-1:0] sacc_q, sacc_d, sacc_mac;
  logic [VEC_W-1:0]    lane_x;
  logic [SEG_W-1:0]    scal_x;
  logic signed [63:0]  sacc_sh;
  logic                bank_hit;

  assign bank_hit = reg_we && (reg_sel < SEL_SLO);
  assign sacc_sh  = sx64(64'(sacc_q), SCALAR_W, 1'b1) >>> shamt;
  assign scal_x   = SEG_W'(clip(sacc_sh, SEG_W, 1'b1));

  always_comb begin : lanes
    logic signed [63:0] acc, prod, tot;
    acc      = '0;
    prod     = '0;
    bank_mac = bank_q;
    lane_x   = '0;
    tot      = sx64(64'(sacc_q), SCALAR_W, is_signed);
    for (int i = 0; i < NL; i++) begin
      if (!wide) begin
        acc  = sx64(64'(bank_q[NARROW_ACC_W*i +: NARROW_ACC_W]), NARROW_ACC_W, is_signed);
        prod = sx64(64'(opa[LN*i +: LN]), LN, is_signed) * sx64(64'(opb[LN*i +: LN]), LN, is_signed);
        bank_mac[NARROW_ACC_W*i +: NARROW_ACC_W] = NARROW_ACC_W'(clip(acc + prod, NARROW_ACC_W, is_signed));
        lane_x[LN*i +: LN] = LN'(clip(acc >>> shamt, LN, is_signed));
        tot = tot + prod;
      end else if (i < WL) begin
        acc  = sx64(64'(bank_q[WIDE_ACC_W*i +: WIDE_ACC_W]), WIDE_ACC_W, is_signed);
        prod = sx64(64'(opa[LW*i +: LW]), LW, is_signed) * sx64(64'(opb[LW*i +: LW]), LW, is_signed);
        bank_mac[WIDE_ACC_W*i +: WIDE_ACC_W] = WIDE_ACC_W'(clip(acc + prod, WIDE_ACC_W, is_signed));
        lane_x[LW*i +: LW] = LW'(clip(acc >>> shamt, LW, is_signed));
        tot = tot + prod;
      end
    end
    sacc_mac = SCALAR_W'(clip(tot, SCALAR_W, is_signed));
  end

  always_comb begin
    bank_d = bank_q;
    if (bank_hit) begin
      for (int k = 0; k < 2 * NSEG; k++)
        if (reg_sel == SEL_W'(k)) bank_d[seg_pos(k) +: SEG_W] = reg_wdata;
    end else if (op == OP_MACL) bank_d = bank_mac;
    else if (op == OP_CLRL) bank_d = '0;
  end

  always_comb begin
    sacc_d = sacc_q;
    if (reg_we && reg_sel == SEL_SLO) sacc_d[SEG_W-1:0] = reg_wdata;
    else if (reg_we && reg_sel == SEL_SHI) sacc_d[SCALAR_W-1:SEG_W] = reg_wdata[SCALAR_W-SEG_W-1:0];
    else begin
      case (op)
        OP_MACS: sacc_d = sacc_mac;
        OP_CLRS: sacc_d = '0;
        OP_XS:   sacc_d = SCALAR_W'(sacc_sh);
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < 2 * NSEG; k++)
      if (reg_sel == SEL_W'(k)) reg_rdata = bank_q[seg_pos(k) +: SEG_W];
    if (reg_sel == SEL_SLO) reg_rdata = sacc_q[SEG_W-1:0];
    if (reg_sel == SEL_SHI) reg_rdata = SEG_W'(sacc_q[SCALAR_W-1:SEG_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q     <= '0;
      sacc_q     <= '0;
      lane_out   <= '0;
      scalar_out <= '0;
    end else begin
      bank_q <= bank_d;
      sacc_q <= sacc_d;
      if (op == OP_XL) lane_out <= lane_x;
      if (op == OP_XS) scalar_out <= scal_x;
    end
  end

endmodule

// File: rtl/vmac_acc_chk.sv
module vmac_acc_chk #(
  parameter int BANK_W   = 320,
  parameter int SCALAR_W = 40,
  parameter int SEG_W    = 32,
  parameter int SEL_W    = 4,
  parameter int NSEG     = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          op,
  input logic                is_signed,
  input logic                reg_we,
  input logic [SEL_W-1:0]    reg_sel,
  input logic [SEG_W-1:0]    reg_wdata,
  input logic [BANK_W-1:0]   bank,
  input logic [SCALAR_W-1:0] sacc
);
  localparam logic [SEL_W-1:0] SLO = SEL_W'(2 * NSEG);
  localparam logic [SEL_W-1:0] SHI = SEL_W'(2 * NSEG + 1);

  logic s_hit, b_hit;
  assign s_hit = reg_we && (reg_sel == SLO || reg_sel == SHI);
  assign b_hit = reg_we && (reg_sel < SLO);

  AST_CLR_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd3 && !s_hit) |=> (sacc == '0)); // R9
  AST_CLR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && !b_hit) |=> (bank == '0)); // R9
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && (op == 3'd0 || op == 3'd5 || op == 3'd7)) |=> ($stable(bank) && $stable(sacc))); // R11
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SLO) |=> (sacc[SEG_W-1:0] == $past(reg_wdata))); // R10
  AST_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SHI) |=> (sacc[SCALAR_W-1:SEG_W] == $past(reg_wdata[SCALAR_W-SEG_W-1:0]))); // R6
  AST_UNSIGNED_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd1 && !is_signed && !s_hit) |=> (sacc >= $past(sacc))); // R2
endmodule

bind vmac_acc vmac_acc_chk #(
  .BANK_W(BANK_W), .SCALAR_W(SCALAR_W), .SEG_W(SEG_W), .SEL_W(SEL_W), .NSEG(NSEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .is_signed(is_signed), .reg_we(reg_we),
  .reg_sel(reg_sel), .reg_wdata(reg_wdata), .bank(bank_q), .sacc(sacc_q)
);

// File: tb/tb_vmac_acc.sv
module tb_vmac_acc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   op = '0;
  logic         wide = 1'b0, is_signed = 1'b0;
  logic [127:0] opa = '0, opb = '0;
  logic [5:0]   shamt = '0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_sel = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [127:0] lane_out;
  logic [31:0]  scalar_out;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [319:0] mbank = '0;
  logic [39:0]  msacc = '0;
  logic [127:0] mlane = '0;
  logic [31:0]  mscal = '0;

  always #4 clk = ~clk;

  vmac_acc dut (.clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .is_signed(is_signed),
    .opa(opa), .opb(opb), .shamt(shamt), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lane_out(lane_out), .scalar_out(scalar_out));

  function automatic longint lv(input logic [319:0] v, input int w, input int i, input bit s);
    logic [63:0] raw;
    longint r;
    raw = 64'(v >> (w * i)) & ((64'd1 << w) - 64'd1);
    r = longint'(raw);
    if (s && raw[w-1]) r = r - (longint'(1) << w);
    return r;
  endfunction

  function automatic longint sat(input longint v, input int w, input bit s);
    longint top, bot;
    if (s) begin top = (longint'(1) << (w - 1)) - 1; bot = -(longint'(1) << (w - 1)); end
    else begin top = (longint'(1) << w) - 1; bot = 0; end
    if (v > top) return top;
    if (v < bot) return bot;
    return v;
  endfunction

  function automatic logic [31:0] hsh(input int a, input int b);
    return 32'(a * 32'h9E3779B1) ^ 32'(b * 32'h85EBCA77) ^ 32'h5BD1E995;
  endfunction

  function automatic logic [127:0] hvec(input int a);
    return {hsh(a, 0), hsh(a, 1), hsh(a, 2), hsh(a, 3)};
  endfunction

  function automatic logic [31:0] mseg(input int k);
    if (k < 5) return mbank[160 + 32 * k +: 32];
    if (k < 10) return mbank[32 * (k - 5) +: 32];
    if (k == 10) return msacc[31:0];
    if (k == 11) return {24'd0, msacc[39:32]};
    return 32'd0;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      reg_sel = 4'(k);
      #1;
      check(req, 128'(reg_rdata), 128'(mseg(k)));
    end
  endtask

  task automatic do_op(input logic [2:0] o, input bit w, input bit s, input logic [127:0] a,
                       input logic [127:0] b, input int sh, input bit we, input int sel,
                       input logic [31:0] wd);
    logic [319:0] nb;
    logic [39:0]  ns;
    longint acc, p, sum, v;
    int n, aw, ew;
    bit bconf, sconf;
    nb = mbank; ns = msacc;
    n  = w ? 8 : 16; aw = w ? 40 : 20; ew = w ? 16 : 8;
    bconf = we && sel < 10;
    sconf = we && (sel == 10 || sel == 11);
    sum = 0;
    for (int i = 0; i < n; i++) begin
      p = lv(320'(a), ew, i, s) * lv(320'(b), ew, i, s);
      sum = sum + p;
      acc = lv(mbank, aw, i, s);
      if (o == 3'd2 && !bconf) begin
        v = sat(acc + p, aw, s);
        for (int j = 0; j < aw; j++) nb[aw * i + j] = v[j];
      end
      if (o == 3'd5) begin
        v = sat(acc >>> sh, ew, s);
        for (int j = 0; j < ew; j++) mlane[ew * i + j] = v[j];
      end
    end
    if (o == 3'd4 && !bconf) nb = '0;
    if (bconf) begin
      if (sel < 5) nb[160 + 32 * sel +: 32] = wd;
      else nb[32 * (sel - 5) +: 32] = wd;
    end
    if (o == 3'd1 && !sconf) ns = 40'(sat(lv(320'(msacc), 40, 0, s) + sum, 40, s));
    if (o == 3'd3 && !sconf) ns = '0;
    if (o == 3'd6) begin
      v = lv(320'(msacc), 40, 0, 1'b1) >>> sh;
      mscal = 32'(sat(v, 32, 1'b1));
      if (!sconf) ns = 40'(v);
    end
    if (we && sel == 10) ns[31:0] = wd;
    if (we && sel == 11) ns[39:32] = wd[7:0];
    @(negedge clk);
    op = o; wide = w; is_signed = s; opa = a; opb = b; shamt = 6'(sh);
    reg_we = we; reg_sel = 4'(sel); reg_wdata = wd;
    @(posedge clk);
    #1;
    mbank = nb; msacc = ns;
    op = 3'd0; reg_we = 1'b0;
  endtask

  task automatic load_bank(input logic [319:0] img);
    for (int k = 0; k < 10; k++)
      do_op(3'd0, 0, 0, '0, '0, 0, 1, k, k < 5 ? img[160 + 32 * k +: 32] : img[32 * (k - 5) +: 32]);
  endtask

  task automatic load_scalar(input logic [39:0] v);
    do_op(3'd0, 0, 0, '0, '0, 0, 1, 10, v[31:0]);
    do_op(3'd0, 0, 0, '0, '0, 0, 1, 11, {24'hA5A5A5, v[39:32]});
  endtask

  initial begin
    logic [319:0] img;
    logic [127:0] a, b;
    logic [39:0]  lanes40 [5];
    logic [39:0]  svals [5];
    int shs [11];
    lanes40 = '{40'h7FC0000000, 40'h8040000000, 40'hFFC0000000, 40'h0000000010, 40'h00FFFFFFF0};
    svals   = '{40'h7FFFFFFFFF, 40'h8000000000, 40'h0012345678, 40'hFF00000001, 40'h00FFFFFFFF};
    shs     = '{0, 1, 4, 9, 15, 19, 20, 31, 39, 40, 63};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", lane_out, '0);
    check("R1", 128'(scalar_out), '0);
    check_regs("R1");

    // R5 bank segments
    for (int k = 0; k < 10; k++) do_op(3'd0, 0, 0, '0, '0, 0, 1, k, hsh(k, 77));
    check_regs("R5");
    // R6 scalar segments, high write keeps low byte only
    do_op(3'd0, 0, 0, '0, '0, 0, 1, 10, 32'h13579BDF);
    do_op(3'd0, 0, 0, '0, '0, 0, 1, 11, 32'hABCDEF5A);
    check_regs("R6");
    @(negedge clk); reg_sel = 4'd13; #1;
    check("R6", 128'(reg_rdata), '0);

    // R9 clears
    do_op(3'd3, 0, 0, '0, '0, 0, 0, 0, '0);
    check_regs("R9");
    load_scalar(40'h12_3456_789A);
    do_op(3'd4, 0, 0, '0, '0, 0, 0, 0, '0);
    check_regs("R9");

    // R3 byte-lane accumulation with saturation
    for (int s = 0; s < 2; s++) begin
      do_op(3'd4, 0, 0, '0, '0, 0, 0, 0, '0);
      for (int k = 0; k < 40; k++) begin
        a = hvec(k + 100 * s); b = hvec(k + 500);
        a[7:0] = 8'hFF; b[7:0] = 8'hFF;
        a[15:8] = 8'h80; b[15:8] = 8'h7F;
        a[23:16] = 8'h80; b[23:16] = 8'h80;
        do_op(3'd2, 0, s[0], a, b, 0, 0, 0, '0);
        if (k % 8 == 7) check_regs("R3");
      end
    end

    // R4 halfword-lane accumulation from boundary preloads
    for (int s = 0; s < 2; s++)
      for (int seed = 0; seed < 5; seed++) begin
        for (int i = 0; i < 8; i++) img[40 * i +: 40] = lanes40[(i + seed) % 5];
        load_bank(img);
        for (int k = 0; k < 3; k++) begin
          a = hvec(k + seed); b = hvec(k + 9);
          a[15:0] = 16'h8000; b[15:0] = 16'h8000;
          a[31:16] = 16'hFFFF; b[31:16] = 16'hFFFF;
          a[47:32] = 16'h8000; b[47:32] = 16'h7FFF;
          a[63:48] = 16'h7FFF; b[63:48] = 16'h7FFF;
          do_op(3'd2, 1, s[0], a, b, 0, 0, 0, '0);
          check_regs("R4");
        end
      end

    // R2 scalar accumulation sweeps
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++) begin
        do_op(3'd3, 0, 0, '0, '0, 0, 0, 0, '0);
        for (int k = 0; k < 10; k++) begin
          do_op(3'd1, w[0], s[0], hvec(k + 31 * w), hvec(k + 57 * s), 0, 0, 0, '0);
          check_regs("R2");
        end
      end
    // R2 saturation at both ends
    load_scalar(40'h7F_FFFF_FF00);
    do_op(3'd1, 0, 1, {16{8'h7F}}, {16{8'h7F}}, 0, 0, 0, '0);
    check_regs("R2");
    load_scalar(40'h80_0000_0100);
    do_op(3'd1, 1, 1, {8{16'h8000}}, {8{16'h7FFF}}, 0, 0, 0, '0);
    check_regs("R2");
    load_scalar(40'hFF_FFFF_FF00);
    do_op(3'd1, 0, 0, {16{8'hFF}}, {16{8'hFF}}, 0, 0, 0, '0);
    check_regs("R2");

    // R7 lane extraction
    for (int i = 0; i < 8; i++) img[40 * i +: 40] = (i < 5) ? lanes40[i] : {hsh(i, 3)[7:0], hsh(i, 4)};
    load_bank(img);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 2; s++)
        foreach (shs[j]) begin
          do_op(3'd5, w[0], s[0], '0, '0, shs[j], 0, 0, '0);
          check("R7", lane_out, mlane);
        end
    // R11 extraction and idle leave state alone
    do_op(3'd0, 1, 1, hvec(1), hvec(2), 5, 0, 0, '0);
    do_op(3'd7, 0, 1, hvec(3), hvec(4), 5, 0, 0, '0);
    do_op(3'd5, 0, 0, hvec(5), hvec(6), 3, 0, 0, '0);
    check_regs("R11");

    // R8 scalar extraction with write-back
    foreach (svals[i])
      for (int j = 0; j < 6; j++) begin
        load_scalar(svals[i]);
        do_op(3'd6, 0, 0, '0, '0, shs[(j * 2) % 11], 0, 0, '0);
        check("R8", 128'(scalar_out), 128'(mscal));
        @(negedge clk); reg_sel = 4'd10; #1;
        check("R8", 128'(reg_rdata), 128'(mseg(10)));
        reg_sel = 4'd11; #1;
        check("R8", 128'(reg_rdata), 128'(mseg(11)));
      end

    // R10 register write wins over same-accumulator command
    load_bank(img);
    do_op(3'd2, 1, 1, hvec(40), hvec(41), 0, 1, 3, 32'hCAFEF00D);
    check_regs("R10");
    do_op(3'd1, 0, 1, {16{8'h7F}}, {16{8'h7F}}, 0, 1, 10, 32'h0BADBEEF);
    check_regs("R10");
    do_op(3'd4, 0, 0, '0, '0, 0, 1, 7, 32'h01234567);
    check_regs("R10");
    do_op(3'd3, 0, 0, '0, '0, 0, 1, 11, 32'h00000042);
    check_regs("R10");
    do_op(3'd6, 0, 0, '0, '0, 4, 1, 10, 32'h80000001);
    check("R10", 128'(scalar_out), 128'(mscal));
    check_regs("R10");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule